// File: doc/BRIEF.md
# Pi/4-Shift QPSK Burst Transmit Framer

This block is the symbol side of a burst transmitter. Serial transmit bits come in with a 384 kHz bit clock. The bit clock is either taken from a pin directly or made by dividing a 3.84 MHz pin by ten. The selected clock is also driven back out so that the data source can stay in step with it. While a burst-window input is high, the bits are paired into dibits. Each dibit moves a three-bit phase accumulator, in units of pi/4, by an odd step. This gives the pi/4-shifted differential phase sequence that a downstream shaping filter and DAC pair turn into I/Q.

Each burst opens with two ramp-up symbols and closes with two ramp-down symbols. Both are marked by a ramp flag and hold the phase still. Everything leaves the block through one delay line that is clocked on every edge of the bit clock, four times per symbol. The window output and the symbol stream therefore trail the input window by exactly 6.25 symbols at both ends of the burst. All logic runs on one fast system clock. The bit-clock pins are sampled as levels.

Top module: `qpsk_burst_framer`

## Requirements
- R1: While reset is asserted and right after it, `sym_stb`, `burst_o`, `sym_ramp` and `sym_phase` are all 0.
- R2: With `div_mode` = 0, `bclk_mon` follows `ext_bclk` one system clock later, and `tx_bit` and `tx_win` are sampled on each rising edge of `bclk_mon`.
- R3: With `div_mode` = 1, `bclk_mon` is `fast_clk` divided by 10. It is high for 5 and low for 5 `fast_clk` periods, and bits are sampled on its rising edges.
- R4: The first four bits sampled with `tx_win` high produce two ramp symbols with `sym_ramp` = 1 and `sym_phase` = 0. The values of those four bits have no effect on any symbol.
- R5: The phase accumulator is cleared when a window opens. Each later pair of bits (first bit = MSB) adds to it modulo 8: 00 adds 1, 01 adds 3, 11 adds 5, 10 adds 7. The new value is emitted as a data symbol with `sym_ramp` = 0.
- R6: The first bit sampled with `tx_win` low closes the burst. It and the next three bits give two ramp symbols with `sym_ramp` = 1 that repeat the last data phase, and `burst_o` is 0 for them.
- R7: `burst_o` changes on the 25th `bclk_mon` edge, rising or falling, after the rising edge that sampled the change of `tx_win`. Symbols trail their sampling edge by the same 25 edges.
- R8: `sym_stb` is a one-cycle pulse per symbol, and `sym_phase` and `sym_ramp` change only in cycles where `sym_stb` is 1.
- R9: A data symbol (`sym_ramp` = 0) is emitted only while `burst_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_mode | input | 1 | 0: use `ext_bclk`; 1: use `fast_clk` divided by 10 |
| ext_bclk | input | 1 | External bit clock at the bit rate |
| fast_clk | input | 1 | Clock at ten times the bit rate |
| tx_bit | input | 1 | Serial transmit data |
| tx_win | input | 1 | Burst window; high while the burst is sent |
| bclk_mon | output | 1 | Selected bit clock, driven out for the data source |
| burst_o | output | 1 | Burst window delayed by 6.25 symbols |
| sym_stb | output | 1 | One-cycle strobe per emitted symbol |
| sym_phase | output | 3 | Symbol phase index in units of pi/4 |
| sym_ramp | output | 1 | 1 when the symbol is a ramp symbol |

## Verification
The bench sends bursts whose dibit sequences cover every step value. One of them steps the accumulator past 7 back to 0, which catches a wrong sign or a missing modulo wrap: such a design would give wrong phases from that symbol on. Ramp-up bits are driven with random values, so a mapper that let them through would move the phase of the first ramp symbols away from 0. The bench counts bit-clock edges to the change of `burst_o` at both ends of a burst. A delay line that is off by one stage, or that shifts on only one edge, would move that change by one edge or by whole symbols. The bench also runs the divided-clock mode: a counter with the wrong terminal count would give a `bclk_mon` period other than 10 `fast_clk` periods.

// File: rtl/qbf_pkg.sv
package qbf_pkg;
   localparam int PH_W = 3;

   typedef logic [PH_W-1:0] phase_t;

   typedef struct packed {
      logic   win;
      logic   vld;
      logic   ramp;
      phase_t ph;
   } slot_t;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_RUP  = 2'd1,
      S_DATA = 2'd2,
      S_RDN  = 2'd3
   } fr_state_e;

   function automatic phase_t dibit_step(input logic [1:0] d);
      case (d)
         2'b00:   return phase_t'(1);
         2'b01:   return phase_t'(3);
         2'b11:   return phase_t'(5);
         default: return phase_t'(7);
      endcase
   endfunction
endpackage

// File: rtl/qbf_bitclk.sv
module qbf_bitclk #(
   parameter int DIV_RATIO = 10,
   parameter bit HAS_DIV   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic div_mode,
   input  logic ext_bclk,
   input  logic fast_clk,
   output logic bclk_lvl,
   output logic rise_tk,
   output logic edge_tk
);
   localparam int HALF  = DIV_RATIO / 2;
   localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

   logic ext_q, sel, sel_q, div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_q <= 1'b0;
      else        ext_q <= ext_bclk;
   end

   generate
      if (HAS_DIV) begin : g_div
         logic             fast_q, fast_q2;
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fast_q  <= 1'b0;
               fast_q2 <= 1'b0;
               cnt     <= '0;
               div_q   <= 1'b0;
            end else begin
               fast_q  <= fast_clk;
               fast_q2 <= fast_q;
               if (fast_q && !fast_q2) begin
                  if (cnt == CNT_W'(HALF - 1)) begin
                     cnt   <= '0;
                     div_q <= ~div_q;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
         end
         assign sel = div_mode ? div_q : ext_q;
      end else begin : g_nodiv
         assign div_q = 1'b0;
         assign sel   = ext_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= sel;
   end

   assign bclk_lvl = sel;
   assign rise_tk  = sel & ~sel_q;
   assign edge_tk  = sel ^ sel_q;
endmodule

// File: rtl/qbf_mapper.sv
module qbf_mapper
   import qbf_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  rise_tk,
   input  logic  tx_bit,
   input  logic  tx_win,
   output slot_t slot
);
   fr_state_e  st;
   logic [1:0] cnt;
   logic       half, first, win_lvl;
   phase_t     acc, nxt_ph;
   logic       ev_vld, ev_ramp;
   phase_t     ev_ph;

   assign nxt_ph = acc + dibit_step({first, tx_bit});

   always_comb begin
      ev_vld  = 1'b0;
      ev_ramp = (st != S_DATA);
      ev_ph   = acc;
      case (st)
         S_RUP:   ev_vld = tx_win & cnt[0];
         S_DATA:  begin
            ev_vld = tx_win & half;
            ev_ph  = nxt_ph;
         end
         S_RDN:   ev_vld = cnt[0];
         default: ev_vld = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         cnt     <= '0;
         half    <= 1'b0;
         first   <= 1'b0;
         acc     <= '0;
         win_lvl <= 1'b0;
      end else if (rise_tk) begin
         win_lvl <= tx_win;
         case (st)
            S_IDLE: if (tx_win) begin
               st  <= S_RUP;
               cnt <= 2'd1;
               acc <= '0;
            end
            S_RUP: if (!tx_win) begin
               st  <= S_RDN;
               cnt <= 2'd1;
            end else begin
               cnt <= cnt + 2'd1;
               if (cnt == 2'd3) begin
                  st   <= S_DATA;
                  half <= 1'b0;
               end
            end
            S_DATA: if (!tx_win) begin
               st  <= S_RDN;
               cnt <= 2'd1;
            end else if (!half) begin
               first <= tx_bit;
               half  <= 1'b1;
            end else begin
               acc  <= nxt_ph;
               half <= 1'b0;
            end
            default: begin
               cnt <= cnt + 2'd1;
               if (cnt == 2'd3) st <= S_IDLE;
            end
         endcase
      end
   end

   always_comb begin
      if (rise_tk) slot = '{win: tx_win, vld: ev_vld, ramp: ev_ramp, ph: ev_ph};
      else         slot = '{win: win_lvl, vld: 1'b0, ramp: 1'b0, ph: acc};
   end
endmodule

// File: rtl/qbf_delay.sv
module qbf_delay
   import qbf_pkg::*;
#(
   parameter int DEPTH = 25
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   shift,
   input  slot_t  din,
   output logic   win_o,
   output logic   stb_o,
   output logic   ramp_o,
   output phase_t ph_o
);
   slot_t [DEPTH:0] line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line   <= '0;
         stb_o  <= 1'b0;
         ramp_o <= 1'b0;
         ph_o   <= '0;
      end else begin
         stb_o <= shift & line[DEPTH-1].vld;
         if (shift) begin
            line <= {line[DEPTH-1:0], din};
            if (line[DEPTH-1].vld) begin
               ramp_o <= line[DEPTH-1].ramp;
               ph_o   <= line[DEPTH-1].ph;
            end
         end
      end
   end

   assign win_o = line[DEPTH].win;
endmodule

// File: rtl/qpsk_burst_framer.sv
module qpsk_burst_framer #(
   parameter int DIV_RATIO = 10,
   parameter bit HAS_DIV   = 1'b1,
   parameter int DELAY_Q   = 25
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       div_mode,
   input  logic       ext_bclk,
   input  logic       fast_clk,
   input  logic       tx_bit,
   input  logic       tx_win,
   output logic       bclk_mon,
   output logic       burst_o,
   output logic       sym_stb,
   output logic [2:0] sym_phase,
   output logic       sym_ramp
);
   import qbf_pkg::*;

   generate
      if (DIV_RATIO < 2 || (DIV_RATIO % 2) != 0) begin : g_bad_div
         $error("DIV_RATIO must be even and at least 2");
      end
      if (DELAY_Q < 2) begin : g_bad_dly
         $error("DELAY_Q must be at least 2");
      end
      if (PH_W != 3) begin : g_bad_ph
         $error("phase width must be 3 for eight pi/4 states");
      end
   endgenerate

   logic   rise_tk, edge_tk;
   slot_t  slot;
   phase_t ph_w;

   qbf_bitclk #(.DIV_RATIO(DIV_RATIO), .HAS_DIV(HAS_DIV)) u_bitclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_mode (div_mode),
      .ext_bclk (ext_bclk),
      .fast_clk (fast_clk),
      .bclk_lvl (bclk_mon),
      .rise_tk  (rise_tk),
      .edge_tk  (edge_tk)
   );

   qbf_mapper u_mapper (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_tk (rise_tk),
      .tx_bit  (tx_bit),
      .tx_win  (tx_win),
      .slot    (slot)
   );

   qbf_delay #(.DEPTH(DELAY_Q)) u_delay (
      .clk    (clk),
      .rst_n  (rst_n),
      .shift  (edge_tk),
      .din    (slot),
      .win_o  (burst_o),
      .stb_o  (sym_stb),
      .ramp_o (sym_ramp),
      .ph_o   (ph_w)
   );

   assign sym_phase = ph_w;
endmodule

// File: rtl/qpsk_burst_framer_chk.sv
module qpsk_burst_framer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       div_mode,
   input logic       ext_bclk,
   input logic       bclk_mon,
   input logic       burst_o,
   input logic       sym_stb,
   input logic [2:0] sym_phase,
   input logic       sym_ramp
);
   logic [2:0] last_ph;
   logic       last_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_ph   <= '0;
         last_data <= 1'b0;
      end else if (sym_stb) begin
         last_ph   <= sym_phase;
         last_data <= ~sym_ramp;
      end
   end

   always_comb begin
      if (!rst_n) AST_RESET_QUIET: assert (!sym_stb && !burst_o); // R1
   end

   AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      sym_stb |=> !sym_stb); // R8
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_stb |-> ($stable(sym_phase) && $stable(sym_ramp))); // R8
   AST_DATA_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_stb && !sym_ramp) |-> burst_o); // R9
   AST_PI4_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_stb && !sym_ramp && last_data) |-> (sym_phase[0] != last_ph[0])); // R5
   AST_FIRST_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_stb && !sym_ramp && !last_data) |-> sym_phase[0]); // R5
   AST_MON_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      (!div_mode && $past(!div_mode) && $past(rst_n)) |-> (bclk_mon == $past(ext_bclk))); // R2
endmodule

bind qpsk_burst_framer qpsk_burst_framer_chk u_chk (.*);

// File: tb/qpsk_burst_framer_tb.sv
`timescale 1ns/1ps
module qpsk_burst_framer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       div_mode = 1'b0;
   logic       ext_bclk = 1'b0;
   logic       fast_clk = 1'b0;
   logic       tx_bit = 1'b0;
   logic       tx_win = 1'b0;
   logic       bclk_mon, burst_o, sym_stb, sym_ramp;
   logic [2:0] sym_phase;

   int n_chk = 0;
   int n_fail = 0;
   logic [4:0] expq[$];

   qpsk_burst_framer u_dut (.*);

   always #2 clk = ~clk;

   initial forever begin
      repeat (10) @(posedge clk);
      #1 ext_bclk = ~ext_bclk;
   end
   initial forever begin
      repeat (2) @(posedge clk);
      #1 fast_clk = ~fast_clk;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pops expected {burst, ramp, phase} on each strobe
   always @(negedge clk) begin
      if (rst_n && sym_stb) begin
         if (expq.size() == 0) chk(1'b0, "R8 unexpected symbol", 1, 0);
         else begin
            logic [4:0] e;
            e = expq.pop_front();
            chk({burst_o, sym_ramp, sym_phase} == e, "R4/R5/R6 symbol {burst,ramp,phase}",
                int'({burst_o, sym_ramp, sym_phase}), int'(e));
         end
      end
   end

   task automatic wait_bit();
      @(negedge bclk_mon);
      @(negedge clk);
   endtask

   task automatic edge_delay_chk(input logic lvl, input string req);
      @(posedge bclk_mon);
      repeat (24) @(bclk_mon);
      repeat (3) @(negedge clk);
      chk(burst_o == ~lvl, {req, " before 25th edge"}, int'(burst_o), int'(~lvl));
      @(bclk_mon);
      repeat (3) @(negedge clk);
      chk(burst_o == lvl, {req, " at 25th edge"}, int'(burst_o), int'(lvl));
   endtask

   function automatic logic [2:0] step(input logic [1:0] d);
      case (d)
         2'b00: return 3'd1;
         2'b01: return 3'd3;
         2'b11: return 3'd5;
         default: return 3'd7;
      endcase
   endfunction

   // driver: pushes expected symbols, then drives the burst bit by bit
   task automatic run_burst(input logic [63:0] bits, input int nbits, input bit dly);
      logic [2:0] acc = 3'd0;
      expq.push_back({1'b1, 1'b1, 3'd0});
      expq.push_back({1'b1, 1'b1, 3'd0});
      for (int i = 0; i < nbits; i += 2) begin
         acc = acc + step({bits[i], bits[i+1]});
         expq.push_back({1'b1, 1'b0, acc});
      end
      expq.push_back({1'b0, 1'b1, acc});
      expq.push_back({1'b0, 1'b1, acc});
      wait_bit();
      tx_win = 1'b1;
      if (dly) fork edge_delay_chk(1'b1, "R7 rise"); join_none
      for (int k = 0; k < 4; k++) begin
         tx_bit = 1'($urandom);
         wait_bit();
      end
      for (int i = 0; i < nbits; i++) begin
         tx_bit = bits[i];
         wait_bit();
      end
      tx_win = 1'b0;
      if (dly) fork edge_delay_chk(1'b0, "R7 fall"); join_none
      for (int k = 0; k < 24; k++) begin
         tx_bit = 1'($urandom);
         wait_bit();
      end
   endtask

   task automatic do_reset(input logic mode);
      rst_n = 1'b0;
      div_mode = mode;
      repeat (5) @(negedge clk);
      chk(!sym_stb && !burst_o && sym_phase == 3'd0 && !sym_ramp, "R1 reset outputs",
          int'({sym_stb, burst_o, sym_ramp, sym_phase}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!sym_stb && !burst_o && sym_phase == 3'd0, "R1 after reset",
          int'({sym_stb, burst_o, sym_phase}), 0);
   endtask

   initial begin
      fork
         begin
            repeat (150000) @(posedge clk);
            chk(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
         end
      join_none

      // external bit clock mode
      do_reset(1'b0);
      for (int k = 0; k < 2; k++) begin
         @(posedge ext_bclk);
         repeat (2) @(negedge clk);
         chk(bclk_mon == 1'b1, "R2 monitor high", int'(bclk_mon), 1);
         @(negedge ext_bclk);
         repeat (2) @(negedge clk);
         chk(bclk_mon == 1'b0, "R2 monitor low", int'(bclk_mon), 0);
      end
      // every step value: 00 01 11 10 (first bit is MSB)
      run_burst(64'b01_11_10_00, 8, 1'b1);
      // repeated 11 forces wrap through 7 -> 0
      run_burst(64'hFFFF, 16, 1'b0);
      run_burst(64'hA5C3_96E1, 32, 1'b0);
      chk(expq.size() == 0, "R6 all ext-mode symbols emitted", expq.size(), 0);

      // divided clock mode
      do_reset(1'b1);
      begin
         time t0, t1, t2;
         @(posedge bclk_mon); t0 = $time;
         @(negedge bclk_mon); t1 = $time;
         @(posedge bclk_mon); t2 = $time;
         chk((t2 - t0) == 160, "R3 period 10 fast cycles", int'(t2 - t0), 160);
         chk((t1 - t0) == 80, "R3 high 5 fast cycles", int'(t1 - t0), 80);
      end
      run_burst(64'b10_10_01_00_11_01, 12, 1'b1);
      chk(expq.size() == 0, "R6 all div-mode symbols emitted", expq.size(), 0);

      repeat (20) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule